// File: doc/BRIEF.md
# Boot Phase Sequencer with Clock-Lock Hold

This block carries a device from the end of configuration into user mode by stepping through a fixed run of six startup steps, one step per clock. Software or configuration logic chooses one of those steps as a hold point with a 3-bit selector. When the sequence reaches that step, it waits until every clock manager marked as one to wait for reports lock. Managers not marked are left out of the decision.

A one-clock start pulse starts the run. Lock inputs come from clock managers in other domains, so they pass through a two-flop synchronizer before the hold logic sees them. The wait-enable mask and the step selector are static configuration. They are expected to be stable for the whole run. After the last step completes, the done flag rises and stays high until reset.

Top module: `boot_phase_seq`

## Requirements
- R1: While synchronous reset is high, and in the first clock after it, step_idx is 0 and stalled and done are low.
- R2: A start pulse in idle begins the run. After the k-th rising edge following the start (k = 1..6), step_idx equals k-1. done rises after the 7th edge when no hold occurs.
- R3: When stall_sel is in 0..5 and a wait-enabled manager lacks lock, the run holds at step_idx == stall_sel. step_idx does not change while the hold lasts.
- R4: A manager whose wait_en bit is 0 has no effect on the hold, whatever its lock level.
- R5: With wait_en all zero, the selected step lasts a single clock, and done rises after exactly 7 edges.
- R6: A stall_sel value of 6 or 7 disables the hold. The run completes in 7 edges even with every lock low.
- R7: Lock inputs are synchronized through two flops. If a lock rises before edge a, stalled stays high after edge a, goes low after edge a+1, and step_idx advances after edge a+2.
- R8: done stays high until reset. A start pulse while done is high has no effect: step_idx stays at 5 and stalled stays low.
- R9: stalled is high only while the run is waiting at the hold step. It is low in idle and in user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-clock pulse that starts the run from idle |
| lock_in | input | N_MGR | Lock level from each clock manager (asynchronous) |
| wait_en | input | N_MGR | 1 = the run waits for this manager's lock |
| stall_sel | input | SEL_W | Hold step index; 6 or 7 disables the hold |
| step_idx | output | STEP_W | Current startup step, 0..5 |
| stalled | output | 1 | High while holding for lock |
| done | output | 1 | Sticky user-mode flag |

## Verification
The assertions assume that wait_en and stall_sel stay constant from before the start pulse until done. They also assume that start is a single-clock pulse. The bench changes configuration only while idle or in reset, and always several clocks before a start, so the synchronized lock view has settled. Lock levels are driven on the falling edge, either held steady for a whole run or raised once during a hold to measure the synchronizer delay.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_USER = 2'd2
  } phase_t;

  // Selector values at or above the step count disable the hold.
  function automatic logic sel_armed(input int unsigned sel, input int unsigned nsteps);
    return sel < nsteps;
  endfunction

  // True when the given step is the final one of the run.
  function automatic logic step_final(input int unsigned step, input int unsigned nsteps);
    return step == nsteps - 1;
  endfunction

endpackage

// File: rtl/lock_sync.sv
module lock_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_async;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/stall_gate.sv
module stall_gate
  import boot_seq_pkg::*;
#(
  parameter int N_MGR   = 4,
  parameter int SEL_W   = 3,
  parameter int N_STEPS = 6,
  parameter int STEP_W  = 3
) (
  input  logic [N_MGR-1:0]  lock_s,
  input  logic [N_MGR-1:0]  wait_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [STEP_W-1:0] step,
  output logic              gate_ok,
  output logic              at_hold
);

  logic [N_MGR-1:0] mgr_ok;
  logic             armed;

  // Each manager is satisfied if it is locked or not waited on.
  for (genvar g = 0; g < N_MGR; g++) begin : g_mgr
    assign mgr_ok[g] = lock_s[g] | ~wait_en[g];
  end

  assign gate_ok = &mgr_ok;
  assign armed   = sel_armed(int'(sel), N_STEPS);
  assign at_hold = armed && (int'(step) == int'(sel));

endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
  import boot_seq_pkg::*;
#(
  parameter int N_STEPS = 6,
  parameter int STEP_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              at_hold,
  input  logic              gate_ok,
  output logic [STEP_W-1:0] step,
  output logic              running,
  output logic              holding,
  output logic              advance,
  output logic              in_user
);

  phase_t ph;
  logic   last;

  assign running = (ph == PH_RUN);
  assign in_user = (ph == PH_USER);
  assign holding = running && at_hold && !gate_ok;
  assign advance = running && !holding;
  assign last    = step_final(int'(step), N_STEPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= PH_IDLE;
      step <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          step <= '0;
          if (start) ph <= PH_RUN;
        end
        PH_RUN: begin
          if (advance) begin
            if (last) ph <= PH_USER;
            else      step <= step + 1'b1;
          end
        end
        PH_USER: ph <= PH_USER;
        default: ph <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/boot_phase_seq.sv
module boot_phase_seq
  import boot_seq_pkg::*;
#(
  parameter int N_MGR       = 4,
  parameter int SEL_W       = 3,
  parameter int N_STEPS     = 6,
  parameter int SYNC_STAGES = 2,
  localparam int STEP_W     = $clog2(N_STEPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [N_MGR-1:0]  lock_in,
  input  logic [N_MGR-1:0]  wait_en,
  input  logic [SEL_W-1:0]  stall_sel,
  output logic [STEP_W-1:0] step_idx,
  output logic              stalled,
  output logic              done
);

  logic [N_MGR-1:0] lock_s;
  logic             gate_ok;
  logic             at_hold;
  logic             running;
  logic             advance;

  lock_sync #(.W(N_MGR), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(lock_in), .q_sync(lock_s)
  );

  stall_gate #(.N_MGR(N_MGR), .SEL_W(SEL_W), .N_STEPS(N_STEPS), .STEP_W(STEP_W)) u_gate (
    .lock_s(lock_s), .wait_en(wait_en), .sel(stall_sel), .step(step_idx),
    .gate_ok(gate_ok), .at_hold(at_hold)
  );

  phase_fsm #(.N_STEPS(N_STEPS), .STEP_W(STEP_W)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .at_hold(at_hold), .gate_ok(gate_ok),
    .step(step_idx), .running(running), .holding(stalled), .advance(advance),
    .in_user(done)
  );

endmodule

// File: rtl/boot_phase_seq_chk.sv
module boot_phase_seq_chk #(
  parameter int N_MGR   = 4,
  parameter int SEL_W   = 3,
  parameter int N_STEPS = 6,
  parameter int STEP_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [N_MGR-1:0]  lock_s,
  input logic [N_MGR-1:0]  wait_en,
  input logic [SEL_W-1:0]  stall_sel,
  input logic [STEP_W-1:0] step_idx,
  input logic              stalled,
  input logic              done,
  input logic              running
);

  AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
    (running && !stalled && int'(step_idx) < N_STEPS-1) |=> (step_idx == $past(step_idx) + 1'b1)); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    stalled |=> (step_idx == $past(step_idx))); // R3
  AST_HOLD_AT_SEL: assert property (@(posedge clk) disable iff (rst)
    stalled |-> (int'(stall_sel) < N_STEPS && step_idx == STEP_W'(stall_sel))); // R6
  AST_HOLD_CAUSE: assert property (@(posedge clk) disable iff (rst)
    stalled |-> ((wait_en & ~lock_s) != '0)); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(step_idx))); // R8
  AST_HOLD_ONLY_RUN: assert property (@(posedge clk) disable iff (rst)
    stalled |-> (running && !done)); // R9
  AST_IDLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!running && !done) |-> (step_idx == '0)); // R1

endmodule

bind boot_phase_seq boot_phase_seq_chk #(
  .N_MGR(N_MGR), .SEL_W(SEL_W), .N_STEPS(N_STEPS), .STEP_W(STEP_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .lock_s(lock_s), .wait_en(wait_en),
  .stall_sel(stall_sel), .step_idx(step_idx), .stalled(stalled), .done(done),
  .running(running)
);

// File: tb/boot_phase_seq_tb.sv
module boot_phase_seq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] lock_in = '0;
  logic [3:0] wait_en = '0;
  logic [2:0] stall_sel = '0;
  logic [2:0] step_idx;
  logic       stalled;
  logic       done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  boot_phase_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .lock_in(lock_in), .wait_en(wait_en),
    .stall_sel(stall_sel), .step_idx(step_idx), .stalled(stalled), .done(done)
  );

  // {wait_en, lock_in, stall_sel, expect_hold}
  localparam int NV = 8;
  localparam logic [11:0] VEC [NV] = '{
    {4'b0000, 4'b0000, 3'd2, 1'b0},  // R5
    {4'b1111, 4'b1111, 3'd3, 1'b0},  // R2
    {4'b0101, 4'b0101, 3'd0, 1'b0},  // R4
    {4'b0101, 4'b0100, 3'd4, 1'b1},  // R3
    {4'b1000, 4'b0111, 3'd5, 1'b1},  // R3
    {4'b1111, 4'b0000, 3'd6, 1'b0},  // R6
    {4'b1111, 4'b0000, 3'd7, 1'b0},  // R6
    {4'b0010, 4'b1101, 3'd1, 1'b1}   // R4
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    cyc(1);
    start = 1'b0;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(2);
    chk("R1 step in reset", int'(step_idx), 0);
    chk("R1 done in reset", int'(done), 0);
    rst = 1'b0;
    cyc(1);
    chk("R1 step after reset", int'(step_idx), 0);
    chk("R1 stalled after reset", int'(stalled), 0);

    for (int v = 0; v < NV; v++) begin
      int bad;
      int s;
      do_reset();
      wait_en   = VEC[v][11:8];
      lock_in   = VEC[v][7:4];
      stall_sel = VEC[v][3:1];
      s = int'(VEC[v][3:1]);
      cyc(4);
      start = 1'b1;
      bad = 0;
      if (!VEC[v][0]) begin
        for (int k = 1; k <= 6; k++) begin
          cyc(1);
          start = 1'b0;
          if (int'(step_idx) != k-1 || stalled || done) bad++;
        end
        chk($sformatf("R2 vec%0d step walk mismatches", v), bad, 0);
        cyc(1);
        chk($sformatf("R5 vec%0d done after 7 edges", v), int'(done), 1);
      end else begin
        cyc(1);
        start = 1'b0;
        cyc(s);
        chk($sformatf("R3 vec%0d hold step", v), int'(step_idx), s);
        chk($sformatf("R3 vec%0d stalled", v), int'(stalled), 1);
        cyc(20);
        chk($sformatf("R3 vec%0d step still held", v), int'(step_idx), s);
        chk($sformatf("R9 vec%0d stalled still", v), int'(stalled), 1);
        chk($sformatf("R3 vec%0d no done", v), int'(done), 0);
      end
    end

    // R7: synchronizer latency on release
    do_reset();
    wait_en = 4'b1111; lock_in = 4'b0000; stall_sel = 3'd2;
    cyc(4);
    chk("R9 stalled low in idle", int'(stalled), 0);
    pulse_start();
    cyc(5);
    chk("R7 holding before lock", int'(stalled), 1);
    lock_in = 4'b1111;
    cyc(1);
    chk("R7 stalled after one edge", int'(stalled), 1);
    cyc(1);
    chk("R7 stalled low after two edges", int'(stalled), 0);
    chk("R7 step still at hold", int'(step_idx), 2);
    cyc(1);
    chk("R7 step advanced on third edge", int'(step_idx), 3);
    cyc(3);
    chk("R2 done after release", int'(done), 1);

    // R8: sticky done, start ignored
    pulse_start();
    cyc(5);
    chk("R8 done held", int'(done), 1);
    chk("R8 step stays 5", int'(step_idx), 5);
    chk("R9 stalled low in user mode", int'(stalled), 0);
    lock_in = 4'b0000;
    cyc(4);
    chk("R8 done held after lock loss", int'(done), 1);
    rst = 1'b1;
    cyc(1);
    rst = 1'b0;
    cyc(1);
    chk("R1 reset clears done", int'(done), 0);
    chk("R1 reset clears step", int'(step_idx), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule